// File: doc/BRIEF.md
# Offset one-shot pulse timer

This timer channel produces a single output pulse. The pulse starts a programmable offset after a reference point on a free-running counter, and it lasts a programmable number of counting ticks. Two dividers in series scale the system clock down to the counting tick. A 16-bit free-running counter advances on that tick while its run bit is set. When the counter equals the start compare value, a down-counter that holds the pulse width begins to count and the output pin goes high. The pulse ends when the down-counter reaches zero, and that event raises a sticky interrupt flag.

A second compare value, the terminate compare, can cut a running pulse short. It clears the down-counter at once. Each compare has its own enable bit. Software sets up the channel through a single-cycle register write port. A combinational read port returns the counters and the flag.

Register map, as `wr_addr`/`rd_addr` values:
- 0: first divider, programmed as N-1.
- 1: second divider, programmed as N-1.
- 2: control. Bit 0 is run, bit 1 is start-compare enable, bit 2 is terminate-compare enable, bit 3 is interrupt enable.
- 3: free-running counter.
- 4: start compare.
- 5: terminate compare.
- 6: down-counter (the pulse width).
- 7: status. Bit 0 is the done flag, which is cleared by writing 1. Bit 1 reads the pulse state.

Top module: `oneshot_offset_timer`

## Requirements
- R1: After reset, `pulse_out` and `irq` are 0, and every register reads 0 (both dividers are therefore 1).
- R2: The counting tick occurs once every (D1+1)*(D2+1) clocks, where D1 and D2 are the values written to addresses 0 and 1. The free-running counter advances by one on each tick. The divider phase restarts when run goes to 1.
- R3: While control bit 0 (run) is 0, the free-running counter holds its value and no tick occurs.
- R4: On a tick where the counter equals the start compare, control bit 1 is set, no pulse is running and the down-counter is nonzero, `pulse_out` goes high at the end of that clock.
- R5: A pulse with width W stays high for exactly W ticks. The down-counter decrements on each later tick, and `pulse_out` falls at the end of the clock whose tick moves it from 1 to 0.
- R6: Reaching zero sets status bit 0 in the same clock that the pulse ends.
- R7: `irq` is 1 exactly while status bit 0 and control bit 3 are both 1.
- R8: Writing 1 to status bit 0 clears the flag. When the flag is being set in the same clock, the set wins.
- R9: On a tick where a pulse is running, control bit 2 is set and the counter equals the terminate compare, the down-counter becomes 0 and the pulse ends in that clock. The flag is not set.
- R10: A terminate match while no pulse is running leaves the down-counter and the output unchanged.
- R11: A start match while a pulse is running is ignored, and the pulse keeps its remaining width.
- R12: With control bit 1 at 0, a start match starts no pulse.
- R13: The free-running counter wraps from 0xFFFF to 0x0000.
- R14: The down-counter does not reload after a pulse. A later start match with the down-counter at 0 starts no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 16 | Read data, combinational |
| pulse_out | output | 1 | One-shot pulse output |
| irq | output | 1 | Done interrupt request |

## Verification
The bench builds the block with its default parameters: 16-bit counters and 8-bit divider fields.

Divider settings of 1x1 give one tick per clock, so each pulse takes only a few clocks. A 3x2 setting checks that both stages multiply into the tick period.

Loading the free-running counter near 0xFFFF brings the wrap within a few clocks. Loading the counter just behind a compare value puts start and terminate matches at chosen ticks without waiting for a full counter period.

// File: rtl/oneshot_offset_timer.sv
module oneshot_offset_timer #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             pulse_out,
  output logic             irq
);
  localparam logic [2:0] A_DIV1 = 3'd0, A_DIV2 = 3'd1, A_CTRL = 3'd2, A_FRC = 3'd3,
                         A_STRT = 3'd4, A_TERM = 3'd5, A_DCNT = 3'd6, A_STAT = 3'd7;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [DIV_W-1:0] div1, div2, ph1, ph2;
  logic [3:0]       ctrl;
  logic [CNT_W-1:0] frc, strt_cmp, term_cmp, dcnt;
  logic             active, flag;

  logic run, strt_en, term_en, irq_en;
  assign run     = ctrl[0];
  assign strt_en = ctrl[1];
  assign term_en = ctrl[2];
  assign irq_en  = ctrl[3];

  logic tick1, tick2;
  assign tick1 = run && (ph1 == div1);
  assign tick2 = tick1 && (ph2 == div2);

  logic wr_frc, wr_dcnt, wr_clr;
  assign wr_frc  = wr_en && wr_addr == A_FRC;
  assign wr_dcnt = wr_en && wr_addr == A_DCNT;
  assign wr_clr  = wr_en && wr_addr == A_STAT && wr_data[0];

  logic term_hit, strt_hit, zero_hit;
  assign term_hit = tick2 && active && term_en && frc == term_cmp;
  assign zero_hit = tick2 && active && !term_hit && dcnt == ONE;
  assign strt_hit = tick2 && !active && strt_en && frc == strt_cmp && dcnt != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph1 <= '0;
      ph2 <= '0;
    end else if (!run) begin
      ph1 <= '0;
      ph2 <= '0;
    end else begin
      ph1 <= tick1 ? '0 : ph1 + 1'b1;
      if (tick1) ph2 <= tick2 ? '0 : ph2 + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div1     <= '0;
      div2     <= '0;
      ctrl     <= '0;
      strt_cmp <= '0;
      term_cmp <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_DIV1:  div1     <= wr_data[DIV_W-1:0];
        A_DIV2:  div2     <= wr_data[DIV_W-1:0];
        A_CTRL:  ctrl     <= wr_data[3:0];
        A_STRT:  strt_cmp <= wr_data;
        A_TERM:  term_cmp <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) frc <= '0;
    else if (wr_frc) frc <= wr_data;
    else if (tick2) frc <= frc + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dcnt <= '0;
    else if (wr_dcnt) dcnt <= wr_data;
    else if (term_hit) dcnt <= '0;
    else if (tick2 && active) dcnt <= dcnt - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      flag   <= 1'b0;
    end else begin
      if (strt_hit) active <= 1'b1;
      else if (term_hit || zero_hit) active <= 1'b0;
      if (zero_hit) flag <= 1'b1;
      else if (wr_clr) flag <= 1'b0;
    end
  end

  assign pulse_out = active;
  assign irq       = flag & irq_en;

  always_comb begin
    case (rd_addr)
      A_DIV1:  rd_data = CNT_W'(div1);
      A_DIV2:  rd_data = CNT_W'(div2);
      A_CTRL:  rd_data = CNT_W'(ctrl);
      A_FRC:   rd_data = frc;
      A_STRT:  rd_data = strt_cmp;
      A_TERM:  rd_data = term_cmp;
      A_DCNT:  rd_data = dcnt;
      default: rd_data = CNT_W'({active, flag});
    endcase
  end
endmodule

module oneshot_offset_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick2,
  input logic             pulse_out,
  input logic             irq,
  input logic             flag,
  input logic             irq_en,
  input logic             wr_frc,
  input logic             wr_dcnt,
  input logic [CNT_W-1:0] frc,
  input logic [CNT_W-1:0] dcnt
);
  // R4
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_out) |-> $past(tick2));
  // R5
  fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_out) |-> $past(tick2));
  // R6
  flag_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $fell(pulse_out));
  // R3
  frc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick2) && !$past(wr_frc)) |-> $stable(frc));
  // R14
  dcnt_no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_dcnt) |-> (dcnt <= $past(dcnt)));
  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

bind oneshot_offset_timer oneshot_offset_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick2(tick2), .pulse_out(pulse_out), .irq(irq),
  .flag(flag), .irq_en(irq_en), .wr_frc(wr_frc), .wr_dcnt(wr_dcnt),
  .frc(frc), .dcnt(dcnt)
);

// File: tb/sim_oneshot_offset_timer.sv
module sim_oneshot_offset_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        pulse_out, irq;

  oneshot_offset_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pulse_out(pulse_out), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, hi_cnt = 0;
  bit finished = 0;

  int m_d1, m_d2, m_ctrl, m_frc, m_strt, m_term, m_dc, m_ph;
  bit m_act, m_flag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_d1 = 0; m_d2 = 0; m_ctrl = 0; m_frc = 0; m_strt = 0; m_term = 0;
      m_dc = 0; m_ph = 0; m_act = 0; m_flag = 0;
    end else begin
      int period, nfrc, ndc, nph;
      bit tick, nact, nflag, set;
      period = (m_d1 + 1) * (m_d2 + 1);
      tick = m_ctrl[0] && (m_ph == period - 1);
      nph = !m_ctrl[0] ? 0 : (tick ? 0 : m_ph + 1);
      nfrc = tick ? (m_frc + 1) % 65536 : m_frc;
      ndc = m_dc; nact = m_act; nflag = m_flag; set = 0;
      if (tick && m_act) begin
        if (m_ctrl[2] && m_frc == m_term) begin ndc = 0; nact = 0; end
        else if (m_dc == 1) begin ndc = 0; nact = 0; set = 1; end
        else ndc = m_dc - 1;
      end else if (tick && m_ctrl[1] && m_frc == m_strt && m_dc != 0) nact = 1;
      if (set) nflag = 1;
      else if (wr_en && wr_addr == 7 && wr_data[0]) nflag = 0;
      if (wr_en) begin
        case (wr_addr)
          0: m_d1 = wr_data[7:0];
          1: m_d2 = wr_data[7:0];
          2: m_ctrl = wr_data[3:0];
          3: nfrc = wr_data;
          4: m_strt = wr_data;
          5: m_term = wr_data;
          6: ndc = wr_data;
          default: ;
        endcase
      end
      m_ph = nph; m_frc = nfrc; m_dc = ndc; m_act = nact; m_flag = nflag;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (pulse_out) hi_cnt++;
      total++;
      if (pulse_out !== m_act) begin
        bad++;
        $display("FAIL R4 R5 R9 R11 pulse_out actual=%0b expected=%0b t=%0t", pulse_out, m_act, $time);
      end
      total++;
      if (irq !== (m_flag && m_ctrl[3])) begin
        bad++;
        $display("FAIL R7 irq actual=%0b expected=%0b t=%0t", irq, m_flag && m_ctrl[3], $time);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int a, input int exp);
    @(negedge clk);
    rd_addr = a[2:0];
    #1;
    total++;
    if (rd_data !== exp[15:0]) begin
      bad++;
      $display("FAIL %s addr=%0d actual=%0h expected=%0h", tag, a, rd_data, exp[15:0]);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int keep;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk_int("R1 pulse_out", pulse_out, 0);
    chk_int("R1 irq", irq, 0);
    for (int a = 0; a < 8; a++) chk("R1 reg", a, 0);

    // R2 prescaler: divide by 3 then 2, tick every 6 clocks
    wr(0, 2); wr(1, 1); wr(3, 0);
    wr(2, 1); idle(12); wr(2, 0);
    chk("R2 frc after 13 clocks", 3, 2);

    // R4 R5 R6 main pulse with offset and prescaler
    wr(3, 0); wr(6, 3); wr(4, 2);
    hi_cnt = 0;
    wr(2, 'hB); idle(60);
    chk_int("R5 width 3 ticks of 6 clocks", hi_cnt, 18);
    chk("R6 flag set", 7, 1);
    chk_int("R7 irq enabled", irq, 1);
    chk("R14 dcnt zero after pulse", 6, 0);

    // R8 write-one clear
    wr(7, 0); chk("R8 write 0 keeps flag", 7, 1);
    wr(7, 1); chk("R8 write 1 clears flag", 7, 0);
    chk_int("R8 irq low", irq, 0);

    // R11 start match while running is ignored
    wr(2, 0); wr(0, 0); wr(1, 0); wr(3, 0); wr(6, 10); wr(4, 2);
    hi_cnt = 0;
    wr(2, 'hB); idle(4); wr(3, 2); idle(20);
    chk_int("R11 width kept", hi_cnt, 10);
    chk("R11 flag", 7, 1);
    wr(7, 1);

    // R9 terminate cuts pulse, no flag
    wr(2, 0); wr(3, 0); wr(6, 20); wr(4, 3); wr(5, 8);
    hi_cnt = 0;
    wr(2, 'hF); idle(30);
    chk_int("R9 cut width", hi_cnt, 5);
    chk("R9 dcnt cleared", 6, 0);
    chk("R9 no flag", 7, 0);

    // R10 R12 terminate idle, start disabled
    wr(2, 0); wr(3, 0); wr(6, 4); wr(4, 2); wr(5, 3);
    hi_cnt = 0;
    wr(2, 'h5); idle(10);
    chk("R10 dcnt untouched", 6, 4);
    chk_int("R12 no pulse", hi_cnt, 0);

    // R7 interrupt masked, then unmasked
    wr(2, 0); wr(3, 0); wr(4, 1);
    hi_cnt = 0;
    wr(2, 'h3); idle(15);
    chk_int("R5 width 4", hi_cnt, 4);
    chk("R6 flag", 7, 1);
    chk_int("R7 irq masked", irq, 0);
    wr(2, 'hB); idle(1);
    chk_int("R7 irq unmasked", irq, 1);
    wr(7, 1); idle(1);
    chk_int("R8 irq cleared", irq, 0);

    // R3 counter holds when stopped
    wr(2, 0);
    keep = m_frc;
    idle(10);
    chk("R3 frc held", 3, keep);

    // R13 wrap
    wr(3, 'hFFFE); wr(2, 1); idle(2); wr(2, 0);
    chk("R13 wrap", 3, 1);

    // R14 no reload: start match with dcnt 0
    wr(3, 0); wr(4, 1);
    hi_cnt = 0;
    wr(2, 'h3); idle(8);
    chk_int("R14 no pulse", hi_cnt, 0);
    chk("R14 dcnt stays 0", 6, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule